// File: doc/BRIEF.md
# Multiplexed System Bus Master Interface

This block is the processor-side controller of a shared address/data system bus that links a CPU core to a single external agent. The core hands it one read or write at a time over a simple valid/ready port. The block turns each request into bus cycles on a 64-bit address/data bus, an 8-bit check-bit bus and a 9-bit command/identifier bus. It passes bus ownership to the agent whenever the agent asks for it, and also while a read's data is coming back. All strobes toward the agent are active low. Bus ownership is shown by a drive-enable output and not by tristate modelling.

The controller is a Moore state machine with six named states:
- `ST_IDLE`: the processor owns the bus but drives nothing.
- `ST_WR_ADDR` and `ST_WR_DATA`: the address cycle and then the data cycle of a write.
- `ST_RD_ADDR`: the address cycle of a read.
- `ST_RD_WAIT`: the bus is released and the block waits for the agent's data cycle.
- `ST_EXT_REL`: the bus is released to the agent on its request.

The transitions are:
- IDLE to EXT_REL when an external request is seen. This has priority over core requests.
- IDLE to WR_ADDR when a write is accepted, and IDLE to RD_ADDR when a read is accepted.
- WR_ADDR to WR_DATA, and WR_DATA to IDLE.
- RD_ADDR to RD_WAIT.
- RD_WAIT to IDLE on an inbound data cycle.
- EXT_REL to IDLE once the external request is withdrawn.

Top module: `sysbus_master`

## Requirements
- R1: After reset, `release_n` and `valid_out_n` are high, `bus_oe`, `rd_valid` and `par_err` are low, and the block is idle.
- R2: With the block idle, a low `ext_rqst_n` makes `release_n` go low on the next cycle and stay low while `ext_rqst_n` stays low. `release_n` returns high one cycle after `ext_rqst_n` rises. A request that arrives during a write is granted only after the write's data cycle, with one idle cycle in between.
- R3: An accepted read produces one address cycle (`valid_out_n` low, `cmd_out` = 9'h000). The next cycle has `release_n` low and `bus_oe` low until a cycle with `valid_in_n` low and `cmd_in` = 9'h100. The cycle after that one has `rd_valid` high for one cycle with the sampled data on `rd_data`, and `release_n` high again.
- R4: `req_ready` is high only when the block is idle, `ext_rqst_n` is high, and the ready strobe for the request type is low (`rd_rdy_n` for reads, `wr_rdy_n` for writes). A request that is not ready produces no bus cycle.
- R5: An accepted write produces an address cycle with `cmd_out` = 9'h080, followed directly by a data cycle with `cmd_out` = 9'h100. Both cycles have `valid_out_n` low and `bus_oe` high.
- R6: In an address cycle, `ad_out[35:0]` holds the address and `ad_out[63:36]` is zero. In 32-bit mode (`narrow` high), only `ad_out[31:0]` carries the address.
- R7: In 32-bit mode, a write data cycle drives `ad_out[63:32]` and `chk_out[7:4]` as zero, and `rd_data[63:32]` returns zero.
- R8: In a write data cycle, `chk_out[i]` is the even-parity bit (XOR) of data byte i. In address cycles, `chk_out` is zero.
- R9: On an inbound data cycle, a mismatch between `chk_in[i]` and the XOR of byte i of `ad_in` raises `par_err` for exactly the next cycle. In 32-bit mode, bytes 4 to 7 are ignored.
- R10: `cmd_par` is always low.
- R11: While the bus is released (`release_n` low), `req_ready` is low and core requests are stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow | input | 1 | 32-bit mode select |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 36 | Request address |
| req_wdata | input | 64 | Write data |
| req_ready | output | 1 | Request accepted this cycle |
| rd_valid | output | 1 | Read data return strobe |
| rd_data | output | 64 | Returned read data |
| par_err | output | 1 | Inbound check-bit mismatch pulse |
| ext_rqst_n | input | 1 | Agent asks for the bus (active low) |
| release_n | output | 1 | Bus handed to agent (active low) |
| rd_rdy_n | input | 1 | Agent can take a read (active low) |
| wr_rdy_n | input | 1 | Agent can take a write (active low) |
| valid_in_n | input | 1 | Agent drives valid bus contents (active low) |
| valid_out_n | output | 1 | Block drives valid bus contents (active low) |
| ad_in | input | 64 | Address/data bus, inbound |
| ad_out | output | 64 | Address/data bus, outbound |
| chk_in | input | 8 | Check bits, inbound |
| chk_out | output | 8 | Check bits, outbound |
| cmd_in | input | 9 | Command/identifier, inbound |
| cmd_out | output | 9 | Command/identifier, outbound |
| cmd_par | output | 1 | Command parity, held low |
| bus_oe | output | 1 | Block drives ad/chk/cmd |

## Verification
The hardest situation to reach is an external request that arrives in the middle of a write. It must be deferred through the data cycle and then granted after a single idle cycle. The stimulus reaches it by pulling `ext_rqst_n` low exactly during the write's address cycle and then checking `release_n` cycle by cycle. A second hard case is a parity fault confined to the upper bytes during 32-bit mode, which must not raise `par_err`. The bench builds it by corrupting only `chk_in[7:4]` on a narrow read.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_ADDR,
        ST_WR_DATA,
        ST_RD_ADDR,
        ST_RD_WAIT,
        ST_EXT_REL
    } bus_state_t;

    localparam int CMD_W = 9;
    localparam logic [CMD_W-1:0] CMD_READ  = 9'h000;
    localparam logic [CMD_W-1:0] CMD_WRITE = 9'h080;
    localparam logic [CMD_W-1:0] CMD_DATA  = 9'h100;
endpackage

// File: rtl/sysbus_byte_parity.sv
module sysbus_byte_parity #(
    parameter int DATA_W = 64,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] data,
    output logic [NBYTES-1:0] par
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign par[i] = ^data[8*i +: 8];
    end
endmodule

// File: rtl/sysbus_ctrl.sv
module sysbus_ctrl
    import sysbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       ext_req,
    input  logic       rd_ok,
    input  logic       wr_ok,
    input  logic       data_hit,
    output bus_state_t state,
    output logic       req_ready,
    output logic       drv_addr,
    output logic       drv_data,
    output logic       released
);
    bus_state_t nxt;
    logic       fire;

    assign req_ready = (state == ST_IDLE) && !ext_req && (req_write ? wr_ok : rd_ok);
    assign fire      = req_valid && req_ready;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (ext_req)                nxt = ST_EXT_REL;
                else if (fire && req_write) nxt = ST_WR_ADDR;
                else if (fire)              nxt = ST_RD_ADDR;
            end
            ST_WR_ADDR: nxt = ST_WR_DATA;
            ST_WR_DATA: nxt = ST_IDLE;
            ST_RD_ADDR: nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (data_hit) nxt = ST_IDLE;
            ST_EXT_REL: if (!ext_req) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        drv_addr = 1'b0;
        drv_data = 1'b0;
        released = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_WR_ADDR: drv_addr = 1'b1;
            ST_WR_DATA: drv_data = 1'b1;
            ST_RD_ADDR: drv_addr = 1'b1;
            ST_RD_WAIT: released = 1'b1;
            ST_EXT_REL: released = 1'b1;
            default:    ;
        endcase
    end

    // R4: a read leaves idle only while the agent is read-ready
    p_rd_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && nxt == ST_RD_ADDR) |-> rd_ok);
    // R4: a write leaves idle only while the agent is write-ready
    p_wr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && nxt == ST_WR_ADDR) |-> wr_ok);
    // R5: the data cycle directly follows the write address cycle
    p_wr_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_ADDR) |=> (state == ST_WR_DATA && drv_data));
    // R3: a read address cycle is followed by release
    p_rd_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ADDR) |=> released);
    // R2: an idle external request is granted on the next cycle
    p_ext_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ext_req) |=> released);
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master
    import sysbus_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 36,
    parameter int NARROW_W = 32,
    localparam int CHK_W   = DATA_W / 8,
    localparam int NCHK_N  = NARROW_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              par_err,
    input  logic              ext_rqst_n,
    output logic              release_n,
    input  logic              rd_rdy_n,
    input  logic              wr_rdy_n,
    input  logic              valid_in_n,
    output logic              valid_out_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    input  logic [CHK_W-1:0]  chk_in,
    output logic [CHK_W-1:0]  chk_out,
    input  logic [CMD_W-1:0]  cmd_in,
    output logic [CMD_W-1:0]  cmd_out,
    output logic              cmd_par,
    output logic              bus_oe
);
    localparam logic [DATA_W-1:0] NARROW_DMASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    localparam logic [CHK_W-1:0]  NARROW_CMASK = {{(CHK_W-NCHK_N){1'b0}}, {NCHK_N{1'b1}}};

    bus_state_t        state;
    logic              drv_addr, drv_data, released, data_hit;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] dmask, addr_bus, data_bus;
    logic [CHK_W-1:0]  cmask, par_out, par_in;

    assign dmask    = narrow ? NARROW_DMASK : '1;
    assign cmask    = narrow ? NARROW_CMASK : '1;
    assign data_hit = !valid_in_n && (cmd_in == CMD_DATA);

    sysbus_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .ext_req   (!ext_rqst_n),
        .rd_ok     (!rd_rdy_n),
        .wr_ok     (!wr_rdy_n),
        .data_hit  (data_hit),
        .state     (state),
        .req_ready (req_ready),
        .drv_addr  (drv_addr),
        .drv_data  (drv_data),
        .released  (released)
    );

    sysbus_byte_parity #(.DATA_W(DATA_W)) u_par_out (.data(data_bus), .par(par_out));
    sysbus_byte_parity #(.DATA_W(DATA_W)) u_par_in  (.data(ad_in),    .par(par_in));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_valid && req_ready) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign addr_bus = {{(DATA_W-ADDR_W){1'b0}}, addr_q} & dmask;
    assign data_bus = wdata_q & dmask;

    always_comb begin
        ad_out  = '0;
        chk_out = '0;
        cmd_out = '0;
        if (drv_addr) begin
            ad_out  = addr_bus;
            cmd_out = (state == ST_WR_ADDR) ? CMD_WRITE : CMD_READ;
        end else if (drv_data) begin
            ad_out  = data_bus;
            chk_out = par_out & cmask;
            cmd_out = CMD_DATA;
        end
    end

    assign valid_out_n = !(drv_addr || drv_data);
    assign bus_oe      = drv_addr || drv_data;
    assign release_n   = !released;
    assign cmd_par     = 1'b0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            par_err  <= 1'b0;
        end else begin
            rd_valid <= (state == ST_RD_WAIT) && data_hit;
            if ((state == ST_RD_WAIT) && data_hit) rd_data <= ad_in & dmask;
            par_err  <= data_hit && |((chk_in ^ par_in) & cmask);
        end
    end

    // R11: never drive the bus while it is released
    p_no_drive_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && !release_n));
    // R11: no request accepted while released
    p_stall_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !release_n |-> !req_ready);
    // R6: upper address bits are zero in address cycles
    p_addr_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !cmd_out[8]) |-> (ad_out[DATA_W-1:ADDR_W] == '0));
    // R3: read data return ends the release
    p_rd_return_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> release_n);
    // R9: the parity flag lasts a single cycle per data beat
    p_perr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> $past(!valid_in_n));
endmodule

// File: tb/sysbus_master_tb.sv
module sysbus_master_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        narrow, req_valid, req_write, req_ready;
    logic [35:0] req_addr;
    logic [63:0] req_wdata, rd_data, ad_in, ad_out;
    logic        rd_valid, par_err, ext_rqst_n, release_n, rd_rdy_n, wr_rdy_n;
    logic        valid_in_n, valid_out_n, cmd_par, bus_oe;
    logic [7:0]  chk_in, chk_out;
    logic [8:0]  cmd_in, cmd_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysbus_master u_dut (
        .clk(clk), .rst_n(rst_n), .narrow(narrow),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .par_err(par_err), .ext_rqst_n(ext_rqst_n),
        .release_n(release_n), .rd_rdy_n(rd_rdy_n), .wr_rdy_n(wr_rdy_n),
        .valid_in_n(valid_in_n), .valid_out_n(valid_out_n), .ad_in(ad_in),
        .ad_out(ad_out), .chk_in(chk_in), .chk_out(chk_out), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_par(cmd_par), .bus_oe(bus_oe)
    );

    function automatic logic [7:0] even_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[8*i +: 8];
        return p;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 release_n", release_n, 1);
        check("R1 valid_out_n", valid_out_n, 1);
        check("R1 bus_oe", bus_oe, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 par_err", par_err, 0);
        check("R10 cmd_par", cmd_par, 0);
    endtask

    task automatic t_write(input logic [35:0] a, input logic [63:0] d, input logic m32);
        logic [63:0] ed;
        narrow = m32; req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; wr_rdy_n = 0;
        #1;
        check("R4 req_ready on write", req_ready, 1);
        step();
        req_valid = 0; wr_rdy_n = 1;
        check("R5 addr valid_out_n", valid_out_n, 0);
        check("R5 addr bus_oe", bus_oe, 1);
        check("R5 write cmd", cmd_out, 9'h080);
        check("R6 address", ad_out, m32 ? {32'h0, a[31:0]} : {28'h0, a});
        check("R8 chk in addr cycle", chk_out, 0);
        step();
        ed = m32 ? {32'h0, d[31:0]} : d;
        check("R5 data valid_out_n", valid_out_n, 0);
        check("R5 data cmd", cmd_out, 9'h100);
        check("R7 write data", ad_out, ed);
        check("R8 check bits", chk_out, m32 ? {4'h0, even_par(ed)} : even_par(ed));
        step();
        check("R5 idle after data", valid_out_n, 1);
        check("R10 cmd_par", cmd_par, 0);
    endtask

    task automatic t_read(input logic [35:0] a, input logic [63:0] d, input logic m32,
                          input logic [7:0] flip, input logic exp_err);
        narrow = m32; req_valid = 1; req_write = 0; req_addr = a; rd_rdy_n = 0;
        #1;
        check("R4 req_ready on read", req_ready, 1);
        step();
        rd_rdy_n = 1;
        check("R3 read addr cycle", valid_out_n, 0);
        check("R3 read cmd", cmd_out, 9'h000);
        check("R6 read address", ad_out, m32 ? {32'h0, a[31:0]} : {28'h0, a});
        step();
        check("R3 released", release_n, 0);
        check("R3 no drive", bus_oe, 0);
        check("R11 stalled", req_ready, 0);
        step();
        check("R3 still released", release_n, 0);
        req_valid = 0;
        valid_in_n = 0; ad_in = d; cmd_in = 9'h100; chk_in = even_par(d) ^ flip;
        step();
        valid_in_n = 1; cmd_in = 0;
        check("R3 rd_valid", rd_valid, 1);
        check("R7 rd_data", rd_data, m32 ? {32'h0, d[31:0]} : d);
        check("R9 par_err", par_err, exp_err);
        check("R3 ownership back", release_n, 1);
        step();
        check("R3 rd_valid single", rd_valid, 0);
        check("R9 par_err single", par_err, 0);
    endtask

    task automatic t_not_ready();
        narrow = 0; req_valid = 1; req_write = 0; rd_rdy_n = 1; wr_rdy_n = 0;
        #1;
        check("R4 read blocked", req_ready, 0);
        step();
        check("R4 no read cycle", valid_out_n, 1);
        req_write = 1; wr_rdy_n = 1; rd_rdy_n = 0;
        #1;
        check("R4 write blocked", req_ready, 0);
        step();
        check("R4 no write cycle", valid_out_n, 1);
        req_valid = 0; rd_rdy_n = 1;
    endtask

    task automatic t_ext_idle();
        ext_rqst_n = 0; req_valid = 1; req_write = 1; wr_rdy_n = 0;
        #1;
        check("R4 ext blocks ready", req_ready, 0);
        step();
        check("R2 granted", release_n, 0);
        check("R11 stalled ext", req_ready, 0);
        step();
        check("R2 held", release_n, 0);
        check("R11 no write during ext", valid_out_n, 1);
        ext_rqst_n = 1; req_valid = 0; wr_rdy_n = 1;
        step();
        check("R2 returned", release_n, 1);
    endtask

    task automatic t_ext_during_write();
        narrow = 0; req_valid = 1; req_write = 1; req_addr = 36'h123; req_wdata = 64'h55; wr_rdy_n = 0;
        step();
        req_valid = 0; wr_rdy_n = 1;
        ext_rqst_n = 0;
        check("R2 addr cycle kept", valid_out_n, 0);
        step();
        check("R2 deferred in data", release_n, 1);
        check("R2 data cycle kept", cmd_out, 9'h100);
        step();
        check("R2 idle gap", release_n, 1);
        step();
        check("R2 late grant", release_n, 0);
        ext_rqst_n = 1;
        step();
        check("R2 released back", release_n, 1);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; narrow = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        ext_rqst_n = 1; rd_rdy_n = 1; wr_rdy_n = 1; valid_in_n = 1;
        ad_in = 0; chk_in = 0; cmd_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write(36'hF_DEAD_BEEF, 64'h0123_4567_89AB_CDEF, 0);
        t_write(36'hA_1234_5678, 64'hFFEE_DDCC_0102_0304, 1);
        t_read(36'h8_0000_0040, 64'hCAFE_F00D_1357_9BDF, 0, 8'h00, 0);
        t_read(36'h8_0000_0080, 64'h1111_2222_3333_4444, 0, 8'h20, 1);
        t_read(36'hF_0000_0100, 64'h9999_8888_7777_6666, 1, 8'hF0, 0);
        t_read(36'hF_0000_0200, 64'h9999_8888_7777_6666, 1, 8'h02, 1);
        t_not_ready();
        t_ext_idle();
        t_ext_during_write();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule